// File: doc/BRIEF.md
# 64-bit Interval Timer with Split-Word Access

This peripheral counts prescaled ticks in a 64-bit counter and raises a period flag when the count matches a programmed 64-bit period. Software reaches it over a plain 32-bit register bus with a write strobe, a read strobe, a byte address and data. Two tick inputs stand in for the two possible counting clocks, and a mode bit chooses which one is used. A 4-bit prescaler divides the selected tick stream.

The timer has two modes. In continuous mode it wraps to zero on every period match and keeps running. In one-shot mode it stops on the match until it is started again. The 64-bit period and the 64-bit live count each sit in two 32-bit words. A write to the low period word commits both halves together. A read of the low count word freezes the high count word for the read that follows. The status flag drives an interrupt line through an enable bit, and a read of the status word clears the flag.

Top module: `ptimer64`

## Requirements
- R1: After reset, every register reads 0, the counter is stopped at 0 and `irq` is low.
- R2: Word offsets are: control 0x00, mode 0x04, period low 0x08, period high 0x0C, interrupt enable 0x10, status 0x1C, count low 0x20 and count high 0x24. Mode reads back its bit 0 (continuous), bit 3 (alternate source) and bits 11:8 (prescaler). Enable reads back its bit 0. Control and any unmapped offset read 0.
- R3: A write to period high only stages the value, and period high reads back the staged value. A write to period low makes the period {staged high, written low} in one step. Until that low write, the match keeps using the old period.
- R4: Writing 1 to control bit 0 clears the count and the prescaler and starts the timer. While running, the count advances by one on each prescaler step.
- R5: With prescaler value P, one count step happens for every P+1 ticks of the selected source.
- R6: Mode bit 3 at 1 selects `tickAlt` as the source, and at 0 selects `tickPeriph`. Ticks on the other input have no effect on the count.
- R7: On a step taken while the count equals the period, status bit 0 is set. In continuous mode (mode bit 0 = 1), the count returns to 0 and counting goes on.
- R8: In one-shot mode (mode bit 0 = 0), a match sets status, the timer stops and the count holds the period value. Further ticks are ignored until control bit 0 is written again.
- R9: A read of count low returns the live low word and captures the high word. A later read of count high returns the captured word.
- R10: A read of status returns the flag in bit 0 and clears it. If a match falls in the same cycle as that read, the read returns the old value and the flag stays set.
- R11: `irq` is high exactly when the status flag is set and enable bit 0 is 1.
- R12: Writing 1 to control bit 8 stops the timer and clears the count, the prescaler and the status flag. It keeps mode, period and enable. It overrides a start bit written in the same word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWe | input | 1 | Write strobe, one cycle per write |
| busRe | input | 1 | Read strobe; read side effects occur at the clock edge ending the cycle |
| busAddr | input | 6 | Byte address; bits 5:2 select the word |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, valid during the strobe cycle |
| tickPeriph | input | 1 | Tick enable from the peripheral clock source |
| tickAlt | input | 1 | Tick enable from the alternate clock source |
| irq | output | 1 | Period interrupt |

## Verification
The close call is a status read that lands in the same cycle as a period match. The read must return the flag's prior value of 0, and the new match must survive the clear. The bench provokes this with one bus cycle that carries a status read and a qualifying tick together. It then expects `irq` to stay high and a second status read to return 1, followed by 0 on a third read. A related overlap is a software reset written together with start; there the check is that later ticks leave the count at 0.

// File: rtl/ptimer_pkg.sv
package ptimer_pkg;
  localparam int DATA_W = 32;
  localparam int CNT_W  = 2 * DATA_W;
  localparam int PRES_W = 4;
  localparam int WIDX_W = 4;

  localparam logic [WIDX_W-1:0] IDX_CTRL  = 4'd0;
  localparam logic [WIDX_W-1:0] IDX_MODE  = 4'd1;
  localparam logic [WIDX_W-1:0] IDX_PERLO = 4'd2;
  localparam logic [WIDX_W-1:0] IDX_PERHI = 4'd3;
  localparam logic [WIDX_W-1:0] IDX_IEN   = 4'd4;
  localparam logic [WIDX_W-1:0] IDX_STAT  = 4'd7;
  localparam logic [WIDX_W-1:0] IDX_CNTLO = 4'd8;
  localparam logic [WIDX_W-1:0] IDX_CNTHI = 4'd9;

  localparam int CTRL_GO_BIT   = 0;
  localparam int CTRL_RST_BIT  = 8;
  localparam int MODE_CONT_BIT = 0;
  localparam int MODE_ALT_BIT  = 3;
  localparam int MODE_PRES_LSB = 8;

  typedef struct packed {
    logic start;
    logic swReset;
    logic clrStatus;
    logic capture;
  } tmrStrobe_t;

  typedef struct packed {
    logic              contMode;
    logic              altSrc;
    logic [PRES_W-1:0] pres;
  } tmrCfg_t;
endpackage

// File: rtl/ptimer_regs.sv
module ptimer_regs
  import ptimer_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic [CNT_W-1:0]  cntValue,
  input  logic [DATA_W-1:0] cntHiSnap,
  input  logic              statusFlag,
  output tmrStrobe_t        strobe,
  output tmrCfg_t           cfg,
  output logic [CNT_W-1:0]  period,
  output logic              irqEnable
);
  logic [WIDX_W-1:0] wordIdx;
  logic [DATA_W-1:0] perHiStage;
  logic              wrCtrl, wrMode, wrPerLo, wrPerHi, wrIen;

  assign wordIdx = busAddr[WIDX_W+1:2];
  assign wrCtrl  = busWe && (wordIdx == IDX_CTRL);
  assign wrMode  = busWe && (wordIdx == IDX_MODE);
  assign wrPerLo = busWe && (wordIdx == IDX_PERLO);
  assign wrPerHi = busWe && (wordIdx == IDX_PERHI);
  assign wrIen   = busWe && (wordIdx == IDX_IEN);

  always_comb begin
    strobe.start     = wrCtrl && busWdata[CTRL_GO_BIT];
    strobe.swReset   = wrCtrl && busWdata[CTRL_RST_BIT];
    strobe.clrStatus = busRe && (wordIdx == IDX_STAT);
    strobe.capture   = busRe && (wordIdx == IDX_CNTLO);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfg        <= '0;
      irqEnable  <= 1'b0;
      perHiStage <= '0;
      period     <= '0;
    end else begin
      if (wrMode) begin
        cfg.contMode <= busWdata[MODE_CONT_BIT];
        cfg.altSrc   <= busWdata[MODE_ALT_BIT];
        cfg.pres     <= busWdata[MODE_PRES_LSB +: PRES_W];
      end
      if (wrIen)   irqEnable  <= busWdata[0];
      if (wrPerHi) perHiStage <= busWdata;
      if (wrPerLo) period     <= {perHiStage, busWdata};
    end
  end

  always_comb begin
    busRdata = '0;
    unique case (wordIdx)
      IDX_MODE: begin
        busRdata[MODE_CONT_BIT]               = cfg.contMode;
        busRdata[MODE_ALT_BIT]                = cfg.altSrc;
        busRdata[MODE_PRES_LSB +: PRES_W]     = cfg.pres;
      end
      IDX_PERLO: busRdata = period[DATA_W-1:0];
      IDX_PERHI: busRdata = perHiStage;
      IDX_IEN:   busRdata[0] = irqEnable;
      IDX_STAT:  busRdata[0] = statusFlag;
      IDX_CNTLO: busRdata = cntValue[DATA_W-1:0];
      IDX_CNTHI: busRdata = cntHiSnap;
      default:   busRdata = '0;
    endcase
  end

  // R3
  hi_stage_only_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && wordIdx == IDX_PERHI) |=> (period == $past(period)));
  // R3
  lo_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && wordIdx == IDX_PERLO) |=> (period == {$past(perHiStage), $past(busWdata)}));
endmodule

// File: rtl/ptimer_core.sv
module ptimer_core
  import ptimer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  tmrStrobe_t        strobe,
  input  tmrCfg_t           cfg,
  input  logic [CNT_W-1:0]  period,
  input  logic              tickPeriph,
  input  logic              tickAlt,
  output logic [CNT_W-1:0]  cntValue,
  output logic [DATA_W-1:0] cntHiSnap,
  output logic              statusFlag
);
  logic [PRES_W-1:0] presCnt;
  logic              running;
  logic              srcTick, presDone, step, atPeriod, periodEvt;

  assign srcTick   = cfg.altSrc ? tickAlt : tickPeriph;
  assign presDone  = (presCnt >= cfg.pres);
  assign step      = running && srcTick && presDone;
  assign atPeriod  = (cntValue == period);
  assign periodEvt = step && atPeriod && !strobe.swReset && !strobe.start;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntValue <= '0;
      presCnt  <= '0;
      running  <= 1'b0;
    end else if (strobe.swReset) begin
      cntValue <= '0;
      presCnt  <= '0;
      running  <= 1'b0;
    end else if (strobe.start) begin
      cntValue <= '0;
      presCnt  <= '0;
      running  <= 1'b1;
    end else if (running && srcTick) begin
      if (presDone) begin
        presCnt <= '0;
        if (atPeriod) begin
          if (cfg.contMode) cntValue <= '0;
          else              running  <= 1'b0;
        end else begin
          cntValue <= cntValue + CNT_W'(1);
        end
      end else begin
        presCnt <= presCnt + PRES_W'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 statusFlag <= 1'b0;
    else if (strobe.swReset)   statusFlag <= 1'b0;
    else if (periodEvt)        statusFlag <= 1'b1;
    else if (strobe.clrStatus) statusFlag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rstN)               cntHiSnap <= '0;
    else if (strobe.capture) cntHiSnap <= cntValue[CNT_W-1:DATA_W];
  end

  // R7
  cont_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (periodEvt && cfg.contMode) |=> (cntValue == '0 && running));
  // R8
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (periodEvt && !cfg.contMode) |=> (!running && $stable(cntValue)));
  // R10
  evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    periodEvt |=> statusFlag);
  // R10
  read_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clrStatus && !periodEvt) |=> !statusFlag);
  // R12
  sw_reset_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.swReset |=> (cntValue == '0 && !running && !statusFlag && presCnt == '0));
  // R9
  snap_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |=> (cntHiSnap == $past(cntValue[CNT_W-1:DATA_W])));
  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!running && !strobe.start && !strobe.swReset) |=> $stable(cntValue));
endmodule

// File: rtl/ptimer64.sv
module ptimer64
  import ptimer_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  logic              tickPeriph,
  input  logic              tickAlt,
  output logic              irq
);
  tmrStrobe_t        strobe;
  tmrCfg_t           cfg;
  logic [CNT_W-1:0]  period;
  logic [CNT_W-1:0]  cntValue;
  logic [DATA_W-1:0] cntHiSnap;
  logic              statusFlag;
  logic              irqEnable;

  ptimer_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .cntValue(cntValue), .cntHiSnap(cntHiSnap), .statusFlag(statusFlag),
    .strobe(strobe), .cfg(cfg), .period(period), .irqEnable(irqEnable)
  );

  ptimer_core u_core (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cfg(cfg), .period(period),
    .tickPeriph(tickPeriph), .tickAlt(tickAlt),
    .cntValue(cntValue), .cntHiSnap(cntHiSnap), .statusFlag(statusFlag)
  );

  assign irq = statusFlag && irqEnable;

  // R11
  irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> statusFlag);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rstN |=> (!irq && cntValue == '0));
endmodule

// File: tb/test_ptimer64.sv
module test_ptimer64;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWe = 1'b0;
  logic        busRe = 1'b0;
  logic [5:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        tickPeriph = 1'b0;
  logic        tickAlt = 1'b0;
  logic        irq;
  logic        irqProbe = 1'b0;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  localparam logic [5:0] A_CTRL = 6'h00, A_MODE = 6'h04, A_PERLO = 6'h08,
    A_PERHI = 6'h0C, A_IEN = 6'h10, A_STAT = 6'h1C, A_CNTLO = 6'h20,
    A_CNTHI = 6'h24, A_HOLE = 6'h14;

  typedef struct {
    bit          isIrq;
    logic [31:0] exp;
    string       req;
  } item_t;
  item_t expQ[$];

  ptimer64 i_ptimer64 (
    .clk(clk), .rstN(rstN), .busWe(busWe), .busRe(busRe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .tickPeriph(tickPeriph),
    .tickAlt(tickAlt), .irq(irq)
  );

  always #5 clk = ~clk;

  // monitor: compares results mid-cycle against the scoreboard queue
  always @(negedge clk) begin
    if (busRe || irqProbe) begin
      if (expQ.size() == 0) begin
        failures++;
        $display("FAIL unexpected result, no expected item queued");
      end else begin
        item_t it;
        logic [31:0] act;
        it = expQ.pop_front();
        act = it.isIrq ? {31'b0, irq} : busRdata;
        checks++;
        if (act !== it.exp) begin
          failures++;
          $display("FAIL %s: actual=0x%08h expected=0x%08h", it.req, act, it.exp);
        end
      end
    end
  end

  task automatic busCycle(input logic we, input logic re, input logic [5:0] addr,
                          input logic [31:0] wd, input logic tp, input logic ta,
                          input logic probe);
    @(posedge clk); #1;
    busWe = we; busRe = re; busAddr = addr; busWdata = wd;
    tickPeriph = tp; tickAlt = ta; irqProbe = probe;
    @(posedge clk); #1;
    busWe = 0; busRe = 0; busAddr = '0; busWdata = '0;
    tickPeriph = 0; tickAlt = 0; irqProbe = 0;
  endtask

  task automatic wr(input logic [5:0] addr, input logic [31:0] d);
    busCycle(1, 0, addr, d, 0, 0, 0);
  endtask

  task automatic expectRead(input logic [5:0] addr, input logic [31:0] e, input string req);
    item_t it;
    it.isIrq = 0; it.exp = e; it.req = req;
    expQ.push_back(it);
    busCycle(0, 1, addr, 0, 0, 0, 0);
  endtask

  task automatic expectIrq(input logic e, input string req);
    item_t it;
    it.isIrq = 1; it.exp = {31'b0, e}; it.req = req;
    expQ.push_back(it);
    busCycle(0, 0, 0, 0, 0, 0, 1);
  endtask

  task automatic pulses(input int n, input logic tp, input logic ta);
    for (int i = 0; i < n; i++) busCycle(0, 0, 0, 0, tp, ta, 0);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1 reset state
    expectIrq(0, "R1 irq after reset");
    expectRead(A_CTRL, 0, "R1 control");
    expectRead(A_MODE, 0, "R1 mode");
    expectRead(A_PERLO, 0, "R1 period low");
    expectRead(A_STAT, 0, "R1 status");
    expectRead(A_CNTLO, 0, "R1 count low");

    // R2 readback and map
    wr(A_IEN, 32'h1);
    wr(A_MODE, 32'hFFFF_FF0B);
    expectRead(A_MODE, 32'h0000_0F09, "R2 mode fields");
    wr(A_MODE, 32'h1);
    wr(A_PERHI, 0);
    wr(A_PERLO, 5);
    expectRead(A_MODE, 1, "R2 mode readback");
    expectRead(A_IEN, 1, "R2 enable readback");
    expectRead(A_PERLO, 5, "R2 period low readback");
    expectRead(A_HOLE, 0, "R2 unmapped offset");

    // R4 / R7 continuous counting
    wr(A_CTRL, 1);
    pulses(5, 1, 0);
    expectRead(A_CNTLO, 5, "R4 count after 5 ticks");
    expectIrq(0, "R11 no flag yet");
    expectRead(A_STAT, 0, "R7 no match yet");
    pulses(1, 1, 0);
    expectIrq(1, "R11 irq on match");
    expectRead(A_CNTLO, 0, "R7 wrap to zero");
    expectRead(A_STAT, 1, "R10 status set");
    expectRead(A_STAT, 0, "R10 cleared by read");
    expectIrq(0, "R11 irq drops after clear");
    pulses(3, 1, 0);
    expectRead(A_CNTLO, 3, "R7 keeps counting");

    // R3 staged high word
    wr(A_PERHI, 1);
    expectRead(A_PERHI, 1, "R3 staged high readback");
    pulses(2, 1, 0);
    pulses(1, 1, 0);
    expectRead(A_CNTLO, 0, "R3 old period still used");
    expectRead(A_STAT, 1, "R3 match on old period");
    wr(A_PERHI, 0);
    wr(A_PERLO, 2);
    pulses(3, 1, 0);
    expectRead(A_CNTLO, 0, "R3 new period after low write");
    expectRead(A_STAT, 1, "R3 match on new period");

    // R9 split read
    expectRead(A_CNTLO, 0, "R9 low word");
    expectRead(A_CNTHI, 0, "R9 captured high word");

    // R6 source select
    pulses(2, 0, 1);
    expectRead(A_CNTLO, 0, "R6 alt ignored when not selected");
    wr(A_MODE, 32'h9);
    pulses(2, 0, 1);
    pulses(2, 1, 0);
    expectRead(A_CNTLO, 2, "R6 alt counts, periph ignored");
    pulses(1, 0, 1);
    expectRead(A_CNTLO, 0, "R6 alt wrap");
    expectRead(A_STAT, 1, "R6 alt match");

    // R5 prescaler P=2
    wr(A_MODE, 32'h201);
    wr(A_PERLO, 10);
    wr(A_CTRL, 1);
    pulses(2, 1, 0);
    expectRead(A_CNTLO, 0, "R5 no step before P+1 ticks");
    pulses(1, 1, 0);
    expectRead(A_CNTLO, 1, "R5 step on third tick");
    pulses(5, 1, 0);
    expectRead(A_CNTLO, 2, "R5 partial division");
    pulses(1, 1, 0);
    expectRead(A_CNTLO, 3, "R5 next step");

    // R8 one-shot
    wr(A_MODE, 0);
    wr(A_PERLO, 2);
    wr(A_CTRL, 1);
    pulses(2, 1, 0);
    expectRead(A_STAT, 0, "R8 no flag before match");
    pulses(1, 1, 0);
    expectRead(A_CNTLO, 2, "R8 holds period value");
    expectRead(A_STAT, 1, "R8 flag on match");
    pulses(3, 1, 0);
    expectRead(A_CNTLO, 2, "R8 stopped after match");
    expectRead(A_STAT, 0, "R8 no further match");
    wr(A_CTRL, 1);
    pulses(1, 1, 0);
    expectRead(A_CNTLO, 1, "R8 restart by start");
    pulses(1, 1, 0);

    // R10 read collides with match
    begin
      item_t it;
      it.isIrq = 0; it.exp = 0; it.req = "R10 read returns old flag on collision";
      expQ.push_back(it);
      busCycle(0, 1, A_STAT, 0, 1, 0, 0);
    end
    expectIrq(1, "R10 flag survives colliding read");
    expectRead(A_STAT, 1, "R10 flag kept");
    expectRead(A_STAT, 0, "R10 cleared afterwards");

    // R11 enable gating
    wr(A_IEN, 0);
    wr(A_CTRL, 1);
    pulses(3, 1, 0);
    expectIrq(0, "R11 masked when enable clear");
    expectRead(A_STAT, 1, "R11 flag set while masked");
    wr(A_IEN, 1);

    // R12 software reset
    wr(A_MODE, 1);
    wr(A_CTRL, 1);
    pulses(3, 1, 0);
    pulses(1, 1, 0);
    expectIrq(1, "R12 flag pending before reset");
    wr(A_CTRL, 32'h100);
    expectIrq(0, "R12 flag cleared by reset");
    expectRead(A_STAT, 0, "R12 status cleared");
    expectRead(A_CNTLO, 0, "R12 count cleared");
    pulses(2, 1, 0);
    expectRead(A_CNTLO, 0, "R12 stopped");
    expectRead(A_MODE, 1, "R12 mode kept");
    expectRead(A_PERLO, 2, "R12 period kept");
    wr(A_CTRL, 32'h101);
    pulses(2, 1, 0);
    expectRead(A_CNTLO, 0, "R12 reset overrides start");
    wr(A_CTRL, 1);
    pulses(1, 1, 0);
    expectRead(A_CNTLO, 1, "R4 runs after restart");

    repeat (3) @(posedge clk);
    if (expQ.size() != 0) begin
      failures++;
      $display("FAIL scoreboard: %0d items never compared", expQ.size());
    end
    finishRun();
  end
endmodule